// File: doc/BRIEF.md
# LCD Scan Timing Generator

This block produces the row and column timing for a 1/160 duty passive LCD panel that is driven in two halves. In master mode it divides its clock, which runs at the oscillator rate, into a column latch strobe of 16 clocks. It counts 81 strobes per half-frame, raises a frame marker at the start of every half-frame, and drives two row-driver level-select lines that step through a pattern four half-frames long. In slave mode the internal divider stops. The strobe and frame marker then come from a master, and the block only tracks line position and pattern state from them.

A line index (0 to 80) is exported so that the display-data fetch and the column latch can stay aligned with each strobe. The display-off output is active whenever software requests it. It is also active for the first four frames after any reset, so that the panel stays dark until the timing has settled. All outputs are plain level signals; there is no data stream and no handshake.

Top module: `lcd_scan_timer`

## Requirements
- R1: In master mode, `strobe_o` is low for 8 clocks and then high for 8 clocks, with a period of 16 clocks. The low phase starts at the first clock edge after reset is released.
- R2: `line_idx_o` advances by one at every clock edge where the strobe goes from high to low. It counts 0 to 80 and then returns to 0, which starts a new half-frame group.
- R3: In master mode, `frame_o` is high exactly while `line_idx_o` is 0. It therefore rises twice per 2592-clock frame, at the same edge where the strobe falls.
- R4: A 2-bit group counter advances at each new half-frame. `lvl1_o` is 1 in groups 0 and 1 and 0 in groups 2 and 3.
- R5: `lvl2_o` equals a start value for the current group, XOR bit 0 of `line_idx_o`. The start values for groups 0, 1, 2 and 3 are 1, 0, 0 and 1, so the output toggles on every line advance within a group.
- R6: Reset (active low, asynchronous) clears the divider, the line index, the group counter and the blanking counter. While in reset, in master mode, the outputs are `strobe_o`=0, `line_idx_o`=0, `frame_o`=1, `lvl1_o`=1, `lvl2_o`=1 and `disp_off_o`=1. A reset in the middle of a run has the same effect.
- R7: `disp_off_o` stays 1 until 8 half-frame starts (4 frames) have been counted since reset, whatever the value of `doff_req`. After that, `disp_off_o` equals `doff_req` (active high).
- R8: In slave mode the divider is idle, `strobe_o` equals `ext_strobe` and `frame_o` equals `ext_frame`. The line index changes only at a clock edge where `ext_strobe`, sampled on the previous edge as 1, is now 0.
- R9: In slave mode, if `ext_frame` is 1 at a strobe falling edge, the line index goes to 0 and the group counter advances, even when the count has not reached 80.
- R10: `line_idx_o`, `lvl1_o` and `lvl2_o` all change on the same clock edge as the strobe falling edge that advances the line, with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | 1 = generate timing, 0 = follow external frame and strobe |
| doff_req | input | 1 | Display-off request, active high |
| ext_frame | input | 1 | Frame marker from a master (slave mode), synchronous to clk |
| ext_strobe | input | 1 | Column strobe from a master (slave mode), synchronous to clk |
| strobe_o | output | 1 | Column latch strobe |
| frame_o | output | 1 | Half-frame start marker, active high |
| lvl1_o | output | 1 | Row-driver level select 1 |
| lvl2_o | output | 1 | Row-driver level select 2 |
| line_idx_o | output | LINE_W (7) | Current line within the half-frame, 0 to 80 |
| disp_off_o | output | 1 | Display blank, active high |

## Verification
On every cycle, the embedded properties check the following:
- each line step, the hold between steps and the forced restart in slave mode;
- that the strobe falls at the edge where the line advances;
- that a change in level 1 happens only at a group change, and that level 2 toggles at every step within a group;
- that the blanking counter climbs one half-frame at a time.

Only the bench scenarios can show the exact pattern values in each group. They also show the 2592-clock frame length, the four-frame blanking after both a power-up reset and a mid-run reset, that a display-off request is masked during blanking and followed afterwards, and the realignment when a slave is given a frame marker early.

// File: rtl/lcd_scan_pkg.sv
`timescale 1ns/1ps
package lcd_scan_pkg;

  typedef logic [1:0] grp_t;

  // start value of level select 2 for each half-frame group
  function automatic logic lvl2_seed(input grp_t g);
    return (g == 2'd0) || (g == 2'd3);
  endfunction

  // level select 1 is high for the first two groups of the cycle
  function automatic logic lvl1_of(input grp_t g);
    return ~g[1];
  endfunction

endpackage

// File: rtl/lcd_strobe_div.sv
`timescale 1ns/1ps
module lcd_strobe_div #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master_en,
  input  logic ext_strobe,
  output logic strobe_o,
  output logic step_o
);
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int HALF  = DIV / 2;
  localparam logic [DIV_W-1:0] LAST_CNT = DIV_W'(DIV - 1);
  localparam logic [DIV_W-1:0] HALF_CNT = DIV_W'(HALF);

  logic [DIV_W-1:0] div_q;
  logic             ext_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q      <= '0;
      ext_prev_q <= 1'b0;
    end else begin
      ext_prev_q <= ext_strobe;
      if (!master_en)           div_q <= '0;
      else if (div_q == LAST_CNT) div_q <= '0;
      else                      div_q <= div_q + 1'b1;
    end
  end

  always_comb begin
    if (master_en) begin
      strobe_o = (div_q >= HALF_CNT);
      step_o   = (div_q == LAST_CNT);
    end else begin
      strobe_o = ext_strobe;
      step_o   = ext_prev_q & ~ext_strobe;
    end
  end

  // R1
  strobe_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    master_en && step_o && $past(master_en) |=> !strobe_o && (div_q == '0));

  // R8
  slave_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |=> (div_q == '0));

endmodule

// File: rtl/lcd_line_seq.sv
`timescale 1ns/1ps
module lcd_line_seq
  import lcd_scan_pkg::*;
#(
  parameter int LINES  = 81,
  parameter int LINE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              restart_i,
  output logic [LINE_W-1:0] line_o,
  output grp_t              group_o,
  output logic              half_start_o
);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);

  logic wrap;
  assign wrap         = restart_i || (line_o == LAST_LINE);
  assign half_start_o = step_i && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_o  <= '0;
      group_o <= '0;
    end else if (step_i) begin
      if (wrap) begin
        line_o  <= '0;
        group_o <= group_o + 2'd1;
      end else begin
        line_o  <= line_o + 1'b1;
      end
    end
  end

  // R2
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !restart_i && (line_o != LAST_LINE) |=> line_o == $past(line_o) + 1'b1);

  // R8
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(line_o) && $stable(group_o));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && restart_i |=> (line_o == '0) && (group_o == $past(group_o) + 2'd1));

endmodule

// File: rtl/lcd_level_gen.sv
`timescale 1ns/1ps
module lcd_level_gen
  import lcd_scan_pkg::*;
#(
  parameter int LINE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  grp_t              group_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              lvl1_o,
  output logic              lvl2_o
);
  always_comb begin
    lvl1_o = lvl1_of(group_i);
    lvl2_o = lvl2_seed(group_i) ^ line_i[0];
  end

  // R5
  l2_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_i != $past(line_i)) && (line_i != '0) |-> (lvl2_o != $past(lvl2_o)));

  // R4
  l1_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl1_o) |-> (line_i == '0) && !$stable(group_i));

endmodule

// File: rtl/lcd_blank_ctl.sv
`timescale 1ns/1ps
module lcd_blank_ctl #(
  parameter int BLANK_FRAMES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic half_start_i,
  input  logic doff_req,
  output logic disp_off_o
);
  localparam int HALVES  = 2 * BLANK_FRAMES;
  localparam int BLANK_W = $clog2(HALVES + 1);
  localparam logic [BLANK_W-1:0] LIMIT = BLANK_W'(HALVES);

  logic [BLANK_W-1:0] cnt_q;
  logic               blanking;

  assign blanking = (cnt_q < LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (half_start_i && blanking) cnt_q <= cnt_q + 1'b1;
  end

  assign disp_off_o = doff_req | blanking;

  // R7
  blank_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_start_i && (cnt_q < LIMIT) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R7
  blank_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(disp_off_o) |-> !doff_req && (cnt_q == LIMIT));

endmodule

// File: rtl/lcd_scan_timer.sv
`timescale 1ns/1ps
module lcd_scan_timer
  import lcd_scan_pkg::*;
#(
  parameter int DIV          = 16,
  parameter int LINES        = 81,
  parameter int BLANK_FRAMES = 4,
  parameter int LINE_W       = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_en,
  input  logic              doff_req,
  input  logic              ext_frame,
  input  logic              ext_strobe,
  output logic              strobe_o,
  output logic              frame_o,
  output logic              lvl1_o,
  output logic              lvl2_o,
  output logic [LINE_W-1:0] line_idx_o,
  output logic              disp_off_o
);
  logic step;
  logic half_start;
  grp_t group;

  lcd_strobe_div #(.DIV(DIV)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .master_en  (master_en),
    .ext_strobe (ext_strobe),
    .strobe_o   (strobe_o),
    .step_o     (step)
  );

  lcd_line_seq #(.LINES(LINES), .LINE_W(LINE_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_i       (step),
    .restart_i    (~master_en & ext_frame),
    .line_o       (line_idx_o),
    .group_o      (group),
    .half_start_o (half_start)
  );

  lcd_level_gen #(.LINE_W(LINE_W)) u_lvl (
    .clk     (clk),
    .rst_n   (rst_n),
    .group_i (group),
    .line_i  (line_idx_o),
    .lvl1_o  (lvl1_o),
    .lvl2_o  (lvl2_o)
  );

  lcd_blank_ctl #(.BLANK_FRAMES(BLANK_FRAMES)) u_blank (
    .clk          (clk),
    .rst_n        (rst_n),
    .half_start_i (half_start),
    .doff_req     (doff_req),
    .disp_off_o   (disp_off_o)
  );

  assign frame_o = master_en ? (line_idx_o == '0) : ext_frame;

  // R3
  frame_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    master_en && $past(master_en) && $rose(frame_o) |-> $fell(strobe_o));

  // R10
  step_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_idx_o) |-> $past(step));

endmodule

// File: tb/lcd_scan_timer_test.sv
`timescale 1ns/1ps
module lcd_scan_timer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0, master_en = 1'b1, doff_req = 1'b0;
  logic ext_frame = 1'b0, ext_strobe = 1'b0;
  logic strobe_o, frame_o, lvl1_o, lvl2_o, disp_off_o;
  logic [6:0] line_idx_o;

  lcd_scan_timer uut (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .doff_req(doff_req),
    .ext_frame(ext_frame), .ext_strobe(ext_strobe), .strobe_o(strobe_o),
    .frame_o(frame_o), .lvl1_o(lvl1_o), .lvl2_o(lvl2_o),
    .line_idx_o(line_idx_o), .disp_off_o(disp_off_o)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic       stb, frm, l1, l2, off;
    logic [6:0] line;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  bit   finished = 1'b0;
  int   t = 0, sline = 0, sg = 0, shalf = 0;
  bit   sprev = 1'b0;

  task automatic chk(input string req, input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s (%s) got %0h exp %0h at %0t", req, tag, got, exp, $time);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected outputs
  task automatic cyc(input bit m, input bit r, input bit s, input bit f, input bit req, input string tag);
    exp_t e;
    int line, g, half;
    @(negedge clk);
    master_en = m; rst_n = r; ext_strobe = s; ext_frame = f; doff_req = req;
    @(posedge clk);
    if (!r) begin
      t = 0; sline = 0; sg = 0; shalf = 0; sprev = 1'b0;
    end else if (m) begin
      t++;
    end else begin
      if (sprev && !s) begin
        if (f || sline == 80) begin sline = 0; sg = (sg + 1) % 4; shalf++; end
        else sline++;
      end
      sprev = s;
    end
    if (m) begin
      line = (t / 16) % 81; half = t / 1296; g = half % 4;
      e.stb = ((t % 16) >= 8); e.frm = (line == 0);
    end else begin
      line = sline; half = shalf; g = sg;
      e.stb = s; e.frm = f;
    end
    e.line = line[6:0];
    e.l1   = (g < 2);
    e.l2   = ((g == 0) || (g == 3)) ^ line[0];
    e.off  = req || (half < 8);
    e.tag  = tag;
    q.push_back(e);
  endtask

  // slave strobe: two cycles high, two low; the fall lands on the third
  task automatic pulse(input bit f, input bit req, input string tag);
    cyc(1'b0, 1'b1, 1'b1, f, req, tag);
    cyc(1'b0, 1'b1, 1'b1, f, req, tag);
    cyc(1'b0, 1'b1, 1'b0, f, req, tag);
    cyc(1'b0, 1'b1, 1'b0, f, req, tag);
  endtask

  // monitor: compares away from both clock edges
  always @(posedge clk) begin
    exp_t e;
    #3;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk("R1 R8 strobe", e.tag, 32'(strobe_o), 32'(e.stb));
      chk("R2 R10 line", e.tag, 32'(line_idx_o), 32'(e.line));
      chk("R3 R8 frame", e.tag, 32'(frame_o), 32'(e.frm));
      chk("R4 lvl1", e.tag, 32'(lvl1_o), 32'(e.l1));
      chk("R5 R10 lvl2", e.tag, 32'(lvl2_o), 32'(e.l2));
      chk("R7 disp_off", e.tag, 32'(disp_off_o), 32'(e.off));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R6: reset values in master mode
    repeat (3) cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 reset state");
    // R1 R2 R3 R4 R5: full run past blanking; request masked early (R7), followed late
    for (int i = 0; i < 11000; i++)
      cyc(1'b1, 1'b1, 1'b0, 1'b0, ((i >= 200 && i < 210) || (i >= 10600 && i < 10620)), "master run");
    // R6: a mid-run reset restarts counters and blanking
    repeat (2) cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 mid-run reset");
    for (int i = 0; i < 400; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R6 R7 blank after reset");
    // slave mode
    repeat (3) cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 slave reset");
    for (int i = 0; i < 10; i++) pulse(1'b0, 1'b0, "R8 slave steps");
    for (int i = 0; i < 30; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8 slave idle low");
    for (int i = 0; i < 12; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R8 slave idle high");
    pulse(1'b1, 1'b0, "R9 early frame restart");
    for (int k = 0; k < 7; k++) begin
      for (int i = 0; i < 3; i++) pulse(1'b0, 1'b1, "R7 R8 slave blanking");
      pulse(1'b1, 1'b0, "R9 R7 slave frame");
    end
    for (int i = 0; i < 85; i++) pulse(1'b0, (i % 3) == 0, "R2 R7 slave wrap");
    repeat (2) @(posedge clk);
    #5;
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule